// File: doc/BRIEF.md
# Two-Lane Lifting Row Engine (5/3, single shared lifting element)

This block runs the reversible 5/3 lifting wavelet along image rows while taking one sample per clock. The samples of a row arrive as two interleaved lanes. Samples at even positions of the row stream form lane 0 and samples at odd positions form lane 1, which lets the block carry two independent sequences, such as a first-level and a higher-level sub-band row, through one datapath. Only one pipelined lifting element exists. It alternates between the predict role and the update role in a fixed rhythm: two steps of predict, one for each lane, then two steps of update, one for each lane.

Operands reach the element from fixed taps of an eight-deep right-shifting register bank, and its results go back into the bank in place. A predicted high-pass value replaces the odd sample it was derived from, and an updated low-pass value replaces its even sample. High-pass coefficients leave the block from bank slot 4 and low-pass coefficients from bank slot 8. Each comes with a one-cycle valid strobe and a lane bit. After the last sample of a row the block appends five zero steps of its own to finish the right edge. The next row can begin on the cycle after that.

Top module: `lift_row_unit`

## Requirements
- R1: During and after reset, until the first accepted sample, hiValid and loValid are 0 and modeFlag is 0.
- R2: A row begins with the first sample for which inValid is 1 while the block is idle. Step s of a row (s = 0 for that first sample) runs in predict mode (modeFlag 0) when s mod 4 is 0 or 1, and in update mode (modeFlag 1) when s mod 4 is 2 or 3. Between rows modeFlag reads 0.
- R3: A row holds 2*ROW_LEN samples. Row position p belongs to lane p mod 2 as that lane's sample n = p div 2. The two lanes never mix, and coefLane gives the lane of each output (0 for even positions).
- R4: Lane high-pass output k (0 <= k < ROW_LEN/2) equals x(2k+1) - ((x(2k) + x(2k+2)) >>> 1). The shift is arithmetic and samples outside 0..ROW_LEN-1 count as zero.
- R5: Lane low-pass output k equals x(2k) + ((H(k-1) + H(k)) >>> 2). H(-1) is the R4 expression evaluated at k = -1, which gives -(x(0) >>> 1).
- R6: With no gaps in inValid, high-pass k of lane m is shown on hiData with hiValid in the cycle 4k+6+m cycles after sample 0 is presented. Low-pass k of lane m is shown on loData with loValid 4k+8+m cycles after it.
- R7: Every row yields exactly ROW_LEN/2 high-pass and ROW_LEN/2 low-pass outputs per lane, in index order, each valid for exactly one cycle. hiValid and loValid are never high together.
- R8: A cycle with inValid 0 inside a row is a stall. It moves nothing, hiData and loData hold, and the values produced equal those of the same row without gaps.
- R9: The five flush steps after the last sample run on their own. inValid and inData during those steps have no effect on any output.
- R10: A row started on the cycle right after the previous flush ends gives results that depend only on its own samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A sample is offered on inData this cycle |
| inData | input | DATA_W | Signed input sample |
| modeFlag | output | 1 | Mode of the next step: 0 predict, 1 update |
| hiValid | output | 1 | hiData holds a finished high-pass coefficient |
| hiData | output | DATA_W+2 | Signed high-pass coefficient (bank slot 4) |
| loValid | output | 1 | loData holds a finished low-pass coefficient |
| loData | output | DATA_W+2 | Signed low-pass coefficient (bank slot 8) |
| coefLane | output | 1 | Lane of the coefficient currently flagged valid |

## Verification
With no gaps, each result is due a fixed number of cycles after sample 0 of its row is presented: 4k+6+lane cycles for high-pass index k and 4k+8+lane cycles for low-pass index k. The bench records the cycle in which it presents sample 0 and checks every valid output of a gap-free row against that offset. It also checks modeFlag on each step of such a row against the step number. For rows with random gaps the cycle offsets no longer hold, so those rows are checked only on the order and values of outputs per lane, which a stall must not change. Flush steps fed with junk and rows started with no idle cycle between them are checked the same way.

// File: rtl/lift_pkg.sv
`timescale 1ns/1ps
package lift_pkg;

  // Strobes from the sequencer to the datapath, valid in the current cycle.
  typedef struct packed {
    logic step;      // bank and element advance at this edge
    logic fresh;     // first step of a row: treat all stored state as zero
    logic mode;      // 0 predict, 1 update for the operation issued now
    logic feedZero;  // flush step: shift a zero in instead of inData
  } liftCtrl_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_FLUSH
  } seqState_t;

endpackage

// File: rtl/lift_seq.sv
`timescale 1ns/1ps
module lift_seq
  import lift_pkg::*;
#(
  parameter int ROW_LEN = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output liftCtrl_t ctrl,
  output logic      modeFlag,
  output logic      hiValid,
  output logic      loValid,
  output logic      coefLane
);
  localparam int STEPS_IN  = 2 * ROW_LEN;
  localparam int STEPS_ALL = STEPS_IN + 5;
  localparam int CNT_W     = $clog2(STEPS_ALL + 1);
  localparam int HI_FIRST  = 6;
  localparam int HI_LAST   = STEPS_IN + 3;
  localparam int LO_FIRST  = 8;

  seqState_t         state;
  logic [CNT_W-1:0]  stepCnt;   // steps completed in the current row
  logic [CNT_W-1:0]  nextCnt;
  logic              moved;

  always_comb begin
    ctrl.fresh    = (state == SEQ_IDLE) && inValid;
    ctrl.step     = ctrl.fresh || ((state == SEQ_RUN) && inValid) || (state == SEQ_FLUSH);
    ctrl.mode     = ctrl.fresh ? 1'b0 : stepCnt[1];
    ctrl.feedZero = (state == SEQ_FLUSH);
    nextCnt       = ctrl.fresh ? CNT_W'(1) : stepCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      stepCnt <= CNT_W'(STEPS_ALL);
      moved   <= 1'b0;
    end else begin
      moved <= ctrl.step;
      if (ctrl.step) begin
        stepCnt <= nextCnt;
        if (nextCnt == CNT_W'(STEPS_IN))       state <= SEQ_FLUSH;
        else if (nextCnt == CNT_W'(STEPS_ALL)) state <= SEQ_IDLE;
        else if (ctrl.fresh)                   state <= SEQ_RUN;
      end
    end
  end

  assign modeFlag = (state == SEQ_IDLE) ? 1'b0 : stepCnt[1];
  assign hiValid  = moved && stepCnt[1] &&
                    (stepCnt >= CNT_W'(HI_FIRST)) && (stepCnt <= CNT_W'(HI_LAST));
  assign loValid  = moved && !stepCnt[1] &&
                    (stepCnt >= CNT_W'(LO_FIRST)) && (stepCnt <= CNT_W'(STEPS_ALL));
  assign coefLane = stepCnt[0];

endmodule

// File: rtl/lift_pe.sv
`timescale 1ns/1ps
module lift_pe #(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                clr,
  input  logic                isUpd,
  input  logic signed [W-1:0] opA,
  input  logic signed [W-1:0] opB,
  input  logic signed [W-1:0] opC,
  output logic signed [W-1:0] result,
  output logic                resUpd
);
  localparam int SW = W + 1;

  logic signed [SW-1:0] stSum;
  logic signed [W-1:0]  stHold;
  logic                 stUpd;
  logic signed [SW-1:0] sumView;
  logic signed [W-1:0]  holdView;
  logic signed [SW-1:0] quarter;
  logic signed [SW-1:0] half;

  // Stage 1: pair sum and the value to be corrected.
  always_ff @(posedge clk) begin
    if (rst) begin
      stSum  <= '0;
      stHold <= '0;
      stUpd  <= 1'b0;
    end else if (en) begin
      stSum  <= $signed({opA[W-1], opA}) + $signed({opB[W-1], opB});
      stHold <= opC;
      stUpd  <= isUpd;
    end
  end

  // Stage 2: wired scaling and correction, written back by the bank.
  always_comb begin
    sumView  = clr ? '0 : stSum;
    holdView = clr ? '0 : stHold;
    quarter  = sumView >>> 2;
    half     = sumView >>> 1;
    result   = stUpd ? (holdView + quarter[W-1:0]) : (holdView - half[W-1:0]);
  end

  assign resUpd = stUpd;

endmodule

// File: rtl/lift_bank.sv
`timescale 1ns/1ps
module lift_bank
  import lift_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  liftCtrl_t                ctrl,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [COEF_W-1:0] hiData,
  output logic signed [COEF_W-1:0] loData
);
  localparam int BANK_N  = 8;
  localparam int HI_SLOT = 3;   // slot 4, counted from 1
  localparam int LO_SLOT = 7;   // slot 8, counted from 1

  logic signed [COEF_W-1:0] bank     [BANK_N];
  logic signed [COEF_W-1:0] view     [BANK_N];
  logic signed [COEF_W-1:0] nextBank [BANK_N];
  logic signed [COEF_W-1:0] sampleIn;
  logic signed [COEF_W-1:0] opA, opB, opC, peRes;
  logic                     peUpd;

  assign sampleIn = ctrl.feedZero ? '0 :
                    {{(COEF_W-DATA_W){inData[DATA_W-1]}}, inData};

  always_comb begin
    for (int k = 0; k < BANK_N; k++) view[k] = ctrl.fresh ? '0 : bank[k];
  end

  // Predict: new even sample + slot 4 even sample, slot 2 odd sample.
  // Update : slot 4 and slot 8 high-pass values, slot 6 even sample.
  assign opA = ctrl.mode ? view[HI_SLOT] : sampleIn;
  assign opB = ctrl.mode ? view[LO_SLOT] : view[HI_SLOT];
  assign opC = ctrl.mode ? view[5]       : view[1];

  lift_pe #(.W(COEF_W)) u_pe (
    .clk    (clk),
    .rst    (rst),
    .en     (ctrl.step),
    .clr    (ctrl.fresh),
    .isUpd  (ctrl.mode),
    .opA    (opA),
    .opB    (opB),
    .opC    (opC),
    .result (peRes),
    .resUpd (peUpd)
  );

  generate
    for (genvar k = 0; k < BANK_N; k++) begin : g_slot
      if (k == 0) begin : g_head
        assign nextBank[k] = sampleIn;
      end else if (k == HI_SLOT) begin : g_hi
        assign nextBank[k] = peUpd ? view[k-1] : peRes;
      end else if (k == LO_SLOT) begin : g_lo
        assign nextBank[k] = peUpd ? peRes : view[k-1];
      end else begin : g_plain
        assign nextBank[k] = view[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < BANK_N; k++) bank[k] <= '0;
    end else if (ctrl.step) begin
      for (int k = 0; k < BANK_N; k++) bank[k] <= nextBank[k];
    end
  end

  assign hiData = bank[HI_SLOT];
  assign loData = bank[LO_SLOT];

endmodule

// File: rtl/lift_row_unit.sv
`timescale 1ns/1ps
module lift_row_unit
  import lift_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ROW_LEN = 16,
  parameter int COEF_W  = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     modeFlag,
  output logic                     hiValid,
  output logic signed [COEF_W-1:0] hiData,
  output logic                     loValid,
  output logic signed [COEF_W-1:0] loData,
  output logic                     coefLane
);
  liftCtrl_t ctrl;
  logic      stepStrobe;

  lift_seq #(.ROW_LEN(ROW_LEN)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .modeFlag (modeFlag),
    .hiValid  (hiValid),
    .loValid  (loValid),
    .coefLane (coefLane)
  );

  lift_bank #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .inData (inData),
    .hiData (hiData),
    .loData (loData)
  );

  assign stepStrobe = ctrl.step;

endmodule

// File: rtl/lift_row_chk.sv
`timescale 1ns/1ps
module lift_row_chk #(
  parameter int COEF_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              stepStrobe,
  input logic              modeFlag,
  input logic              hiValid,
  input logic              loValid,
  input logic              coefLane,
  input logic [COEF_W-1:0] hiData,
  input logic [COEF_W-1:0] loData
);
  // R7
  hi_lo_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hiValid && loValid));

  // R7
  hi_lane_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (hiValid && $past(hiValid)) |-> (coefLane != $past(coefLane)));

  // R2
  hi_phase_chk: assert property (@(posedge clk) disable iff (rst)
    hiValid |-> modeFlag);

  // R2
  lo_phase_chk: assert property (@(posedge clk) disable iff (rst)
    loValid |-> !modeFlag);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(stepStrobe) |-> ($stable(hiData) && $stable(loData)));

endmodule

bind lift_row_unit lift_row_chk #(.COEF_W(COEF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stepStrobe (stepStrobe),
  .modeFlag   (modeFlag),
  .hiValid    (hiValid),
  .loValid    (loValid),
  .coefLane   (coefLane),
  .hiData     (hiData),
  .loData     (loData)
);

// File: tb/tb_lift_row_unit.sv
`timescale 1ns/1ps
module tb_lift_row_unit;
  localparam int DATA_W    = 8;
  localparam int ROW_LEN   = 16;
  localparam int COEF_W    = DATA_W + 2;
  localparam int HALF      = ROW_LEN / 2;
  localparam int ROW_SMP   = 2 * ROW_LEN;
  localparam int STEPS_ALL = ROW_SMP + 5;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     inValid = 1'b0;
  logic signed [DATA_W-1:0] inData = '0;
  logic                     modeFlag, hiValid, loValid, coefLane;
  logic signed [COEF_W-1:0] hiData, loData;

  lift_row_unit #(.DATA_W(DATA_W), .ROW_LEN(ROW_LEN)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .modeFlag(modeFlag), .hiValid(hiValid), .hiData(hiData),
    .loValid(loValid), .loData(loData), .coefLane(coefLane)
  );

  always #2.5 clk = ~clk;

  int  checks = 0;
  int  failures = 0;
  int  cycleCnt = 0;
  bit  finished = 0;

  int  xs     [2][ROW_SMP];
  int  expH   [2][2][HALF];
  int  expL   [2][2][HALF];
  int  startCnt [2];
  bit  noStall  [2];
  int  wrBuf = 0;
  int  rdBuf = 0;
  int  hiIdx [2] = '{0, 0};
  int  loIdx [2] = '{0, 0};
  int  rowsDriven = 0;
  int  rowsDone = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int xAt(input int b, input int lane, input int n);
    if (n < 0 || n >= ROW_LEN) return 0;
    return xs[b][2*n + lane];
  endfunction

  // Software 5/3 model per lane, zero extension (R4, R5).
  task automatic computeExp(input int b);
    int hh [HALF+1];
    for (int lane = 0; lane < 2; lane++) begin
      for (int k = -1; k < HALF; k++)
        hh[k+1] = xAt(b, lane, 2*k+1) - ((xAt(b, lane, 2*k) + xAt(b, lane, 2*k+2)) >>> 1);
      for (int k = 0; k < HALF; k++) begin
        expH[b][lane][k] = hh[k+1];
        expL[b][lane][k] = xAt(b, lane, 2*k) + ((hh[k] + hh[k+1]) >>> 2);
      end
    end
  endtask

  // Output monitor, sampled away from the rising edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (hiValid) begin
        automatic int lane = int'(coefLane);
        automatic int k = hiIdx[lane];
        if (k >= HALF) check(1'b0, "R7 extra high-pass", k, HALF - 1);
        else begin
          check(int'(hiData) == expH[rdBuf][lane][k], "R4 high-pass value",
                int'(hiData), expH[rdBuf][lane][k]);
          if (noStall[rdBuf])
            check(cycleCnt - startCnt[rdBuf] == 4*k + 6 + lane, "R6 high-pass timing",
                  cycleCnt - startCnt[rdBuf], 4*k + 6 + lane);
          hiIdx[lane]++;
        end
      end
      if (loValid) begin
        automatic int lane = int'(coefLane);
        automatic int k = loIdx[lane];
        if (k >= HALF) check(1'b0, "R7 extra low-pass", k, HALF - 1);
        else begin
          check(int'(loData) == expL[rdBuf][lane][k], "R5 low-pass value",
                int'(loData), expL[rdBuf][lane][k]);
          if (noStall[rdBuf])
            check(cycleCnt - startCnt[rdBuf] == 4*k + 8 + lane, "R6 low-pass timing",
                  cycleCnt - startCnt[rdBuf], 4*k + 8 + lane);
          loIdx[lane]++;
          if (lane == 1 && loIdx[1] == HALF) begin
            check(hiIdx[0] == HALF && hiIdx[1] == HALF && loIdx[0] == HALF,
                  "R7 R3 per-lane counts", hiIdx[0] + hiIdx[1] + loIdx[0], 3*HALF);
            rowsDone++;
            hiIdx = '{0, 0};
            loIdx = '{0, 0};
            rdBuf ^= 1;
          end
        end
      end
    end
  end

  // pattern: 0 random, 1 all max, 2 all min, 3 alternating extremes, 4 lanes differ
  task automatic driveRow(input int pattern, input int stallPct, input bit junk);
    automatic int b = wrBuf;
    for (int j = 0; j < ROW_SMP; j++) begin
      case (pattern)
        1:       xs[b][j] = 127;
        2:       xs[b][j] = -128;
        3:       xs[b][j] = ((j >> 1) % 2 == 0) ? 127 : -128;
        4:       xs[b][j] = (j % 2 == 0) ? 100 : -(j * 3);
        default: xs[b][j] = int'($urandom % 256) - 128;
      endcase
    end
    computeExp(b);
    noStall[b] = (stallPct == 0);
    wrBuf ^= 1;
    rowsDriven++;
    for (int j = 0; j < ROW_SMP; j++) begin
      while (stallPct != 0 && int'($urandom % 100) < stallPct) begin
        inValid = 1'b0;
        inData  = DATA_W'($urandom);
        @(posedge clk); #1;
      end
      inValid = 1'b1;
      inData  = DATA_W'(xs[b][j]);
      if (j == 0) startCnt[b] = cycleCnt;
      if (stallPct == 0)
        check(modeFlag == 1'(((j >> 1) & 1)), "R2 mode flag", int'(modeFlag), (j >> 1) & 1);
      @(posedge clk); #1;
    end
    // Flush steps: inputs must have no effect (R9).
    for (int f = 0; f < 5; f++) begin
      inValid = junk;
      inData  = DATA_W'($urandom);
      if (stallPct == 0)
        check(modeFlag == 1'((((ROW_SMP + f) >> 1) & 1)), "R2 flush mode flag",
              int'(modeFlag), ((ROW_SMP + f) >> 1) & 1);
      @(posedge clk); #1;
    end
    inValid = 1'b0;
    check(modeFlag == 1'b0, "R2 idle mode flag", int'(modeFlag), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check(!hiValid && !loValid, "R1 valids in reset", int'(hiValid) + int'(loValid), 0);
    check(modeFlag == 1'b0, "R1 flag in reset", int'(modeFlag), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(!hiValid && !loValid && !modeFlag, "R1 idle after reset",
          int'(hiValid) + int'(loValid) + int'(modeFlag), 0);

    driveRow(0, 0, 1'b0);     // random, gap-free (R3..R6)
    driveRow(1, 0, 1'b0);     // positive extreme, back-to-back (R10)
    driveRow(2, 0, 1'b0);     // negative extreme
    driveRow(3, 0, 1'b1);     // alternating extremes, junk during flush (R9)
    driveRow(4, 0, 1'b0);     // lanes with unrelated content (R3)
    repeat (2) @(posedge clk); #1;
    driveRow(0, 30, 1'b0);    // stalls (R8)
    driveRow(0, 60, 1'b1);    // heavy stalls and junk flush (R8, R9)
    for (int r = 0; r < 8; r++) begin
      driveRow(0, (r % 2 == 1) ? int'($urandom % 50) : 0, 1'($urandom));
      repeat (int'($urandom % 3)) @(posedge clk);
      #1;
    end
    repeat (12) @(posedge clk); #1;
    check(rowsDone == rowsDriven, "R7 rows completed", rowsDone, rowsDriven);
    check(!hiValid && !loValid, "R7 no output when idle", int'(hiValid) + int'(loValid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycleCnt, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule